// File: doc/BRIEF.md
# NAND Prefetch Engine Register and Interrupt Front End

This block holds the software-visible control state of a NAND prefetch/postwrite engine and turns the datapath's FIFO fill level and completion events into an interrupt and a gated DMA request. It keeps a configuration word, a 14-bit transfer count, a run bit, a two-bit status and a two-bit interrupt enable. The configuration word carries the direction, the DMA gate, the engine enable, a 7-bit fill threshold and a 3-bit chip select.

When software starts the engine, the block sends one-cycle strobes to the datapath. One tells the datapath to load its remaining count from the stored transfer count. In read direction, a second strobe asks for a FIFO refill. When software stops a running engine, a stop strobe tells the datapath to force its remaining count to zero. While the engine runs, the configuration and the count cannot be changed. A terminal-count pulse from the datapath ends the run and latches a completion status.

The FIFO-event status follows the fill level: it is set on every cycle in which the FIFO pointer is at or above the threshold. The completion status is set only by the terminal-count pulse. Both are write-1-to-clear.

Top module: `nand_prefetch_ctrl`

## Requirements
- R1: A write with `reg_sel`=0 while idle stores `wr_data & 32'h7f8f7fbf` into `cfg_word`. Its fields are: bit 0 selects write direction, bit 2 enables DMA, bit 7 enables the engine, bits 14:8 hold the threshold and bits 26:24 hold the chip select, which also drives `chip_sel`.
- R2: A write with `reg_sel`=1 while idle stores `wr_data[13:0]` into `xfer_count`.
- R3: While `running` is 1, writes to `reg_sel` 0 and 1 leave `cfg_word` and `xfer_count` unchanged.
- R4: A `reg_sel`=2 write with `wr_data[0]`=1 while idle sets `running` and pulses `start_strobe` for one cycle. In the same cycle `refill_strobe` pulses, but only when `cfg_word[0]`=0 (read direction).
- R5: A `reg_sel`=2 write with `wr_data[0]`=0 while running clears `running` and pulses `stop_strobe` for one cycle.
- R6: A `reg_sel`=2 write whose bit 0 equals the current `running` value produces no strobe and leaves `running` unchanged.
- R7: `status[0]` is set after every cycle in which `fifo_ptr >= cfg_word[14:8]`, and it stays set until it is cleared.
- R8: `term_pulse` sets `status[1]` and clears `running`. It takes precedence over a control write in the same cycle, so that write causes no strobe.
- R9: A `reg_sel`=3 write clears each status bit whose `wr_data` bit is 1. A bit whose set condition is active in the same cycle stays set.
- R10: A `reg_sel`=4 write stores `wr_data[1:0]` as the interrupt enable. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R11: `dma_req` equals `dp_dma_req` when `cfg_word[2]`=1, and is 0 otherwise.
- R12: Reset clears the configuration, the count, `running`, the strobes, the status, the enable and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 config, 1 count, 2 control, 3 status clear, 4 interrupt enable |
| wr_data | input | 32 | Write data |
| fifo_ptr | input | 7 | FIFO fill pointer from datapath |
| term_pulse | input | 1 | Terminal-count event from datapath |
| dp_dma_req | input | 1 | Raw DMA request from datapath |
| cfg_word | output | 32 | Stored configuration word |
| xfer_count | output | 14 | Stored transfer count |
| chip_sel | output | 3 | Selected chip select |
| running | output | 1 | Engine run bit |
| start_strobe | output | 1 | Load remaining count, one cycle |
| refill_strobe | output | 1 | Request FIFO refill on read start, one cycle |
| stop_strobe | output | 1 | Force remaining count to zero, one cycle |
| status | output | 2 | Bit 0 FIFO event, bit 1 terminal count |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | Gated DMA request |

## Verification
Every register and status effect appears one clock edge after the cycle in which its write, pointer value or pulse was sampled. `irq` follows the registered status with no added delay. `dma_req` is combinational and follows `dp_dma_req` within the same cycle. The bench drives inputs on the falling edge and samples one time unit after the following rising edge, so every check sees the cycle just committed. The threshold sweep pairs each pointer value with a status-clear write, which makes the expected `status[0]` and `irq` depend on that single cycle alone.

// File: rtl/nand_prefetch_ctrl.sv
module nand_prefetch_ctrl #(
  parameter int CNT_W = 14,
  parameter int PTR_W = 7,
  parameter int CS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      wr_data,
  input  logic [PTR_W-1:0] fifo_ptr,
  input  logic             term_pulse,
  input  logic             dp_dma_req,
  output logic [31:0]      cfg_word,
  output logic [CNT_W-1:0] xfer_count,
  output logic [CS_W-1:0]  chip_sel,
  output logic             running,
  output logic             start_strobe,
  output logic             refill_strobe,
  output logic             stop_strobe,
  output logic [1:0]       status,
  output logic             irq,
  output logic             dma_req
);
  localparam logic [31:0] CFG_MASK = 32'h7f8f7fbf;
  localparam int THR_LSB = 8;
  localparam int CS_LSB  = 24;
  localparam logic [2:0] SEL_CFG = 3'd0, SEL_CNT = 3'd1, SEL_CTL = 3'd2,
                         SEL_CLR = 3'd3, SEL_IEN = 3'd4;

  logic [1:0] ien_q;
  logic [PTR_W-1:0] thr;
  logic fifo_hit, ctl_chg;
  logic [1:0] clr, st_next;

  assign thr      = cfg_word[THR_LSB +: PTR_W];
  assign fifo_hit = fifo_ptr >= thr;
  assign ctl_chg  = reg_wr && reg_sel == SEL_CTL && !term_pulse && (wr_data[0] != running);
  assign clr      = (reg_wr && reg_sel == SEL_CLR) ? wr_data[1:0] : 2'b00;
  assign st_next  = (status & ~clr) | {term_pulse, fifo_hit};

  assign chip_sel = cfg_word[CS_LSB +: CS_W];
  assign irq      = |(ien_q & status);
  assign dma_req  = dp_dma_req & cfg_word[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_word      <= '0;
      xfer_count    <= '0;
      running       <= 1'b0;
      start_strobe  <= 1'b0;
      refill_strobe <= 1'b0;
      stop_strobe   <= 1'b0;
      status        <= '0;
      ien_q         <= '0;
    end else begin
      start_strobe  <= ctl_chg && wr_data[0];
      refill_strobe <= ctl_chg && wr_data[0] && !cfg_word[0];
      stop_strobe   <= ctl_chg && !wr_data[0];
      if (term_pulse)   running <= 1'b0;
      else if (ctl_chg) running <= wr_data[0];
      if (reg_wr && !running && reg_sel == SEL_CFG) cfg_word <= wr_data & CFG_MASK;
      if (reg_wr && !running && reg_sel == SEL_CNT) xfer_count <= wr_data[CNT_W-1:0];
      if (reg_wr && reg_sel == SEL_IEN) ien_q <= wr_data[1:0];
      status <= st_next;
    end
  end

  assert_cfg_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CFG && running) |=> $stable(cfg_word));
  assert_cnt_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_CNT && running) |=> $stable(xfer_count));
  assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> (running && !stop_strobe));
  assert_stop_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_strobe |-> !running);
  assert_fifo_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_hit |=> status[0]);
  assert_term_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> (!running && status[1] && !start_strobe && !stop_strobe));
  assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cfg_word[2]);
endmodule

// File: tb/test_nand_prefetch_ctrl.sv
module test_nand_prefetch_ctrl;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, reg_wr = 0, term_pulse = 0, dp_dma_req = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] wr_data = 0;
  logic [6:0] fifo_ptr = 0;
  logic [31:0] cfg_word;
  logic [13:0] xfer_count;
  logic [2:0] chip_sel;
  logic running, start_strobe, refill_strobe, stop_strobe, irq, dma_req;
  logic [1:0] status;
  int n_chk = 0, n_fail = 0, cyc = 0;

  nand_prefetch_ctrl i_nand_prefetch_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; wr_data = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  initial begin
    dp_dma_req = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(cfg_word, 0, "R12 cfg"); chk(xfer_count, 0, "R12 count");
    chk(running, 0, "R12 run"); chk(status, 0, "R12 status");
    chk(irq, 0, "R12 irq"); chk(dma_req, 0, "R12/R11 dma gated");
    @(negedge clk); rst_n = 1;

    wr(0, 32'hFFFF_FFFF);
    chk(cfg_word, 32'h7f8f7fbf, "R1 mask"); chk(chip_sel, 7, "R1 cs all");
    chk(dma_req, 1, "R11 dma pass");
    wr(0, 32'h0300_0A01);
    chk(cfg_word, 32'h0300_0A01, "R1 fields"); chk(chip_sel, 3, "R1 cs");
    chk(dma_req, 0, "R11 dma blocked");
    wr(0, 32'h0200_0A84);
    chk(dma_req, 1, "R11 dma enabled");
    wr(1, 32'hFFFF);
    chk(xfer_count, 14'h3fff, "R2 count mask");
    wr(1, 32'h0123);
    chk(xfer_count, 14'h0123, "R2 count");

    wr(2, 1);
    chk(running, 1, "R4 run"); chk(start_strobe, 1, "R4 start");
    chk(refill_strobe, 1, "R4 refill read");
    @(negedge clk); @(posedge clk); #1;
    chk(start_strobe, 0, "R4 one cycle"); chk(refill_strobe, 0, "R4 refill one cycle");
    wr(2, 1);
    chk(start_strobe, 0, "R6 no restart"); chk(running, 1, "R6 run kept");
    wr(0, 32'h0500_0001);
    chk(cfg_word, 32'h0200_0A84, "R3 cfg locked");
    wr(1, 32'h0055);
    chk(xfer_count, 14'h0123, "R3 count locked");
    wr(2, 0);
    chk(running, 0, "R5 stopped"); chk(stop_strobe, 1, "R5 stop strobe");
    wr(2, 0);
    chk(stop_strobe, 0, "R6 no restop"); chk(running, 0, "R6 idle kept");

    wr(0, 32'h0000_7F01);
    wr(2, 1);
    chk(start_strobe, 1, "R4 start write"); chk(refill_strobe, 0, "R4 no refill write");
    @(negedge clk); term_pulse = 1; reg_wr = 1; reg_sel = 2; wr_data = 0;
    @(posedge clk); #1; term_pulse = 0; reg_wr = 0;
    chk(running, 0, "R8 term clears run"); chk(stop_strobe, 0, "R8 precedence");
    chk(status[1], 1, "R8 status1");
    chk(irq, 0, "R10 masked");
    wr(4, 2);
    chk(irq, 1, "R10 enabled");
    wr(3, 2);
    chk(status[1], 0, "R9 clear status1"); chk(irq, 0, "R10 cleared");
    @(negedge clk); term_pulse = 1; reg_wr = 1; reg_sel = 3; wr_data = 2;
    @(posedge clk); #1; term_pulse = 0; reg_wr = 0;
    chk(status[1], 1, "R9 set wins");
    wr(3, 2);

    fifo_ptr = 7'd127;
    wr(3, 1);
    chk(status[0], 1, "R9 hold while active");
    wr(4, 1);
    for (int t = 0; t < 128; t++) begin
      wr(0, t << 8);
      for (int p = 0; p < 128; p++) begin
        @(negedge clk); fifo_ptr = p[6:0]; reg_wr = 1; reg_sel = 3; wr_data = 1;
        @(posedge clk); #1; reg_wr = 0;
        chk(status[0], (p >= t) ? 1 : 0, "R7 threshold sweep");
        chk(irq, (p >= t) ? 1 : 0, "R10 sweep irq");
      end
    end
    fifo_ptr = 0;
    wr(0, 32'h0000_0500);
    @(negedge clk); @(posedge clk); #1;
    chk(status[0], 1, "R7 held after drop");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule